// File: doc/BRIEF.md
# PLL Reference Switchover Sequencer

This block orders the recovery steps around a phase-locked loop whose reference clock can move from a primary input to a secondary input. It runs on a free-running system clock that does not come from the PLL. It watches two clock-bad flags, one per reference, and the PLL lock indication. From these it drives four things: a one-cycle manual switch strobe, the phase-detector enable, a timed PLL reset and the output clock enable. Downstream logic therefore never runs on the clock while it settles.

When a reference fails, the phase detector is frozen so the oscillator holds its last frequency. The outputs are gated off at the same time. A user switch request is honoured only while both references run. After the switch, the PLL is reset for a minimum time, and then the phase detector is re-enabled. The outputs come back only once lock has held for a set number of consecutive cycles. If lock never arrives, a timeout records a sticky failure and the reset is tried again. A status word reports the current step, the active reference and two sticky error flags.

Top module: `pll_swover_seq`

## Requirements
- R1: While rst_n is low, status_o is 0 and ref_swap_o, pd_en_o, pll_rst_o and out_en_o are all low (state IDLE). On the first clock edge after release, the block enters RESET.
- R2: status_o[2:0] holds the state code: IDLE=0, FREEZE=1, SWITCH=2, RESET=3, WAIT_LOCK=4, STABLE=5, RUN=6. status_o[3] is the active reference (0 = primary). status_o[4] is a sticky request-rejected flag. status_o[5] is a sticky lock-fail flag. Both sticky flags clear only on reset.
- R3: ref_bad_a_i, ref_bad_b_i and pll_lock_i each pass through a two-flop synchronizer. A change applied between edges T and T+1 first changes the state at edge T+3.
- R4: In RUN, WAIT_LOCK or STABLE, a synchronized bad flag on either reference moves the block to FREEZE. In FREEZE, pd_en_o and out_en_o are low.
- R5: A swap_req_i high at an edge in RUN, with both synchronized bad flags low, gives RUN→FREEZE→SWITCH→RESET on successive edges. ref_swap_o is high for exactly the one SWITCH cycle, and status_o[3] toggles on entry to RESET.
- R6: A swap_req_i high at an edge while either synchronized bad flag is high is not acted on and sets status_o[4]. A request in any state other than RUN with both flags low is ignored.
- R7: In FREEZE, once both synchronized bad flags are low and no request was accepted, the block goes to RESET and keeps the same active reference.
- R8: pll_rst_o stays high for exactly max(MIN_RST, rst_len_i) cycles, with rst_len_i sampled on the edge that enters RESET. MIN_RST = ceil(RST_MIN_NS*1000 / CLK_PERIOD_PS), and is at least 1.
- R9: pd_en_o is high exactly in WAIT_LOCK, STABLE and RUN. It is therefore restored on the cycle after the PLL reset ends, before lock is awaited.
- R10: WAIT_LOCK moves to STABLE on an edge where synchronized lock is high. STABLE moves to RUN after LOCK_STABLE consecutive cycles of synchronized lock. A low lock in STABLE returns to WAIT_LOCK and restarts the count.
- R11: out_en_o is high only in RUN.
- R12: If LOCK_TMO cycles pass in WAIT_LOCK and STABLE together, counted from entry to WAIT_LOCK, without reaching RUN, the block goes to RESET and sets status_o[5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_bad_a_i | input | 1 | Primary reference bad flag (asynchronous) |
| ref_bad_b_i | input | 1 | Secondary reference bad flag (asynchronous) |
| pll_lock_i | input | 1 | PLL lock indication (asynchronous) |
| swap_req_i | input | 1 | User request to change reference (synchronous) |
| rst_len_i | input | RST_LEN_W | Requested PLL reset length in cycles |
| ref_swap_o | output | 1 | One-cycle manual switch strobe to the PLL |
| pd_en_o | output | 1 | Phase-detector enable |
| pll_rst_o | output | 1 | PLL reset |
| out_en_o | output | 1 | Output clock enable |
| status_o | output | 6 | {lock_fail, req_err, active, state[2:0]} |

## Verification
All outputs are decoded from the registered state, so a swap request at edge T shows as FREEZE at T+1, as the strobe at T+2 and as RESET with the toggled reference at T+3. An asynchronous flag driven between edges T and T+1 reaches the state only at T+3. The reset lasts exactly the effective length, lock qualification takes LOCK_STABLE further cycles, and the timeout fires LOCK_TMO cycles after entry to WAIT_LOCK. The driver computes each due cycle from these latencies and queues the complete expected output word for it. The monitor compares the outputs at the falling edge of exactly that cycle, so an early or late transition is reported along with a wrong value.

// File: rtl/pll_swover_pkg.sv
`timescale 1ns/1ps
package pll_swover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FREEZE = 3'd1,
    ST_SWITCH = 3'd2,
    ST_RESET  = 3'd3,
    ST_WAIT   = 3'd4,
    ST_STABLE = 3'd5,
    ST_RUN    = 3'd6
  } swo_state_e;

  localparam int STATUS_W = 6;

endpackage

// File: rtl/swo_sync.sv
`timescale 1ns/1ps
module swo_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic meta_q;
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
        end else begin
          meta_q <= d_i[gi];
          sync_q <= meta_q;
        end
      end
      assign q_o[gi] = sync_q;
    end
  endgenerate

endmodule

// File: rtl/swo_timer.sv
`timescale 1ns/1ps
module swo_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/swo_lock_qual.sv
`timescale 1ns/1ps
module swo_lock_qual #(
  parameter int LOCK_STABLE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lock_i,
  output logic stable_o
);

  localparam int LQ_W = $clog2(LOCK_STABLE + 1);

  logic [LQ_W-1:0] cnt_q;
  logic [LQ_W-1:0] cnt_d;
  logic            at_end;

  assign at_end = (cnt_q == LQ_W'(LOCK_STABLE - 1));

  always_comb begin
    if (!en_i || !lock_i) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + LQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign stable_o = en_i && lock_i && at_end;

endmodule

// File: rtl/swo_fsm.sv
`timescale 1ns/1ps
module swo_fsm
  import pll_swover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bad_a_i,
  input  logic       bad_b_i,
  input  logic       lock_i,
  input  logic       req_i,
  input  logic       rst_done_i,
  input  logic       tmo_done_i,
  input  logic       lock_stable_i,
  output swo_state_e state_o,
  output swo_state_e next_o,
  output logic       active_o,
  output logic       req_err_o,
  output logic       lock_fail_o
);

  swo_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       act_q, act_d;
  logic       err_q, err_d;
  logic       fail_q, fail_d;
  logic       bad_any;

  assign bad_any = bad_a_i || bad_b_i;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    act_d   = act_q;
    err_d   = err_q || (req_i && bad_any);
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: state_d = ST_RESET;
      ST_RUN: begin
        if (bad_any) begin
          state_d = ST_FREEZE;
        end else if (req_i) begin
          state_d = ST_FREEZE;
          pend_d  = 1'b1;
        end
      end
      ST_FREEZE: begin
        if (!bad_any) begin
          state_d = pend_q ? ST_SWITCH : ST_RESET;
        end
      end
      ST_SWITCH: begin
        state_d = ST_RESET;
        pend_d  = 1'b0;
        act_d   = !act_q;
      end
      ST_RESET: begin
        if (rst_done_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (bad_any) begin
          state_d = ST_FREEZE;
        end else if (tmo_done_i) begin
          state_d = ST_RESET;
          fail_d  = 1'b1;
        end else if (lock_i) begin
          state_d = ST_STABLE;
        end
      end
      ST_STABLE: begin
        if (bad_any) begin
          state_d = ST_FREEZE;
        end else if (lock_stable_i) begin
          state_d = ST_RUN;
        end else if (tmo_done_i) begin
          state_d = ST_RESET;
          fail_d  = 1'b1;
        end else if (!lock_i) begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
      err_q   <= err_d;
      fail_q  <= fail_d;
    end
  end

  assign state_o     = state_q;
  assign next_o      = state_d;
  assign active_o    = act_q;
  assign req_err_o   = err_q;
  assign lock_fail_o = fail_q;

endmodule

// File: rtl/pll_swover_seq.sv
`timescale 1ns/1ps
module pll_swover_seq
  import pll_swover_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int RST_MIN_NS    = 10,
  parameter int RST_LEN_W     = 8,
  parameter int LOCK_STABLE   = 64,
  parameter int LOCK_TMO      = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_bad_a_i,
  input  logic                 ref_bad_b_i,
  input  logic                 pll_lock_i,
  input  logic                 swap_req_i,
  input  logic [RST_LEN_W-1:0] rst_len_i,
  output logic                 ref_swap_o,
  output logic                 pd_en_o,
  output logic                 pll_rst_o,
  output logic                 out_en_o,
  output logic [STATUS_W-1:0]  status_o
);

  localparam int MIN_RAW = (RST_MIN_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MIN_RST = (MIN_RAW < 1) ? 1 : MIN_RAW;
  localparam int MIN_W   = $clog2(MIN_RST + 1);
  localparam int RCNT_W  = (RST_LEN_W > MIN_W) ? RST_LEN_W : MIN_W;
  localparam int TMO_W   = $clog2(LOCK_TMO + 1);

  logic [2:0]        async_in, sync_out;
  logic              bad_a_s, bad_b_s, lock_s;
  swo_state_e        state, nxt;
  logic              active, req_err, lock_fail;
  logic              rst_done, tmo_done, lock_stable;
  logic              rst_load, tmo_load;
  logic [RCNT_W-1:0] req_len, eff_len;
  logic [RCNT_W-1:0] rst_min_len;

  assign async_in = {pll_lock_i, ref_bad_b_i, ref_bad_a_i};

  swo_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  assign bad_a_s = sync_out[0];
  assign bad_b_s = sync_out[1];
  assign lock_s  = sync_out[2];

  assign rst_min_len = RCNT_W'(MIN_RST);
  assign req_len     = RCNT_W'(rst_len_i);
  assign eff_len     = (req_len > rst_min_len) ? req_len : rst_min_len;

  assign rst_load = (nxt == ST_RESET) && (state != ST_RESET);
  assign tmo_load = (nxt == ST_WAIT) && (state == ST_RESET);

  swo_timer #(.W(RCNT_W)) u_rst_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (rst_load),
    .load_val_i (eff_len - RCNT_W'(1)),
    .run_i      (state == ST_RESET),
    .done_o     (rst_done)
  );

  swo_timer #(.W(TMO_W)) u_tmo_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmo_load),
    .load_val_i (TMO_W'(LOCK_TMO - 1)),
    .run_i      ((state == ST_WAIT) || (state == ST_STABLE)),
    .done_o     (tmo_done)
  );

  swo_lock_qual #(.LOCK_STABLE(LOCK_STABLE)) u_lockq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (state == ST_STABLE),
    .lock_i   (lock_s),
    .stable_o (lock_stable)
  );

  swo_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .bad_a_i       (bad_a_s),
    .bad_b_i       (bad_b_s),
    .lock_i        (lock_s),
    .req_i         (swap_req_i),
    .rst_done_i    (rst_done),
    .tmo_done_i    (tmo_done),
    .lock_stable_i (lock_stable),
    .state_o       (state),
    .next_o        (nxt),
    .active_o      (active),
    .req_err_o     (req_err),
    .lock_fail_o   (lock_fail)
  );

  assign ref_swap_o = (state == ST_SWITCH);
  assign pll_rst_o  = (state == ST_RESET);
  assign out_en_o   = (state == ST_RUN);
  assign pd_en_o    = (state == ST_WAIT) || (state == ST_STABLE) || (state == ST_RUN);
  assign status_o   = {lock_fail, req_err, active, state};

endmodule

// File: rtl/swo_seq_chk.sv
`timescale 1ns/1ps
module swo_seq_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_swap_o,
  input logic          pd_en_o,
  input logic          pll_rst_o,
  input logic          out_en_o,
  input logic [5:0]    status_o,
  input logic [LW-1:0] min_len
);

  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (!pll_rst_o) begin
      run_len <= '0;
    end else if (run_len != 16'hFFFF) begin
      run_len <= run_len + 16'd1;
    end
  end

  // R5: the strobe lasts one cycle and is followed by the PLL reset
  p_swap_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_swap_o |=> (!ref_swap_o && pll_rst_o));

  // R8: the reset is never shorter than the minimum
  p_rst_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_o) |-> (run_len >= 16'(min_len)));

  // R9: the phase detector and the outputs are off while the PLL is in reset
  p_pd_off_in_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_o |-> (!pd_en_o && !out_en_o));

  // R9: the phase detector is back on the cycle after the reset ends
  p_pd_restored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_o) |-> pd_en_o);

  // R11: the outputs open only after the lock qualification
  p_en_after_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> ($past(status_o[2:0]) == 3'd5));

  // R11: the outputs are never open with the phase detector frozen
  p_en_needs_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> pd_en_o);

  // R12: the lock-fail flag is sticky
  p_fail_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_o[5]) |-> status_o[5]);

  // R6: the request-rejected flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status_o[4]) |-> status_o[4]);

endmodule

bind pll_swover_seq swo_seq_chk #(.LW(RCNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_swap_o (ref_swap_o),
  .pd_en_o    (pd_en_o),
  .pll_rst_o  (pll_rst_o),
  .out_en_o   (out_en_o),
  .status_o   (status_o),
  .min_len    (rst_min_len)
);

// File: tb/pll_swover_seq_test.sv
`timescale 1ns/1ps
module pll_swover_seq_test;

  localparam int RLW = 4;

  logic           clk, rst_n;
  logic           bad_a, bad_b, lock, req;
  logic [RLW-1:0] rst_len;
  logic           sw, pd, prst, en;
  logic [5:0]     st;

  int cyc;
  int n_chk;
  int n_bad;
  bit finished;

  typedef struct {
    int         due;
    logic [9:0] v;
    string      tag;
  } item_t;
  item_t q[$];

  // States: IDLE0 FREEZE1 SWITCH2 RESET3 WAIT4 STABLE5 RUN6
  localparam int S_IDLE = 0, S_FRZ = 1, S_SW = 2, S_RST = 3, S_WAIT = 4, S_STB = 5, S_RUN = 6;

  pll_swover_seq #(
    .CLK_PERIOD_PS (8000),
    .RST_MIN_NS    (10),
    .RST_LEN_W     (RLW),
    .LOCK_STABLE   (4),
    .LOCK_TMO      (30)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_bad_a_i (bad_a),
    .ref_bad_b_i (bad_b),
    .pll_lock_i  (lock),
    .swap_req_i  (req),
    .rst_len_i   (rst_len),
    .ref_swap_o  (sw),
    .pd_en_o     (pd),
    .pll_rst_o   (prst),
    .out_en_o    (en),
    .status_o    (st)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [9:0] mk(int s, bit act, bit err, bit fail);
    logic [9:0] v;
    v[9] = (s == S_SW);
    v[8] = (s == S_WAIT) || (s == S_STB) || (s == S_RUN);
    v[7] = (s == S_RST);
    v[6] = (s == S_RUN);
    v[5:0] = {fail, err, act, 3'(s)};
    return v;
  endfunction

  task automatic compare(logic [9:0] exp_v, string tag);
    logic [9:0] act_v;
    act_v = {sw, pd, prst, en, st};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act_v, exp_v);
    end
  endtask

  task automatic expect_at(int due, int s, bit act, bit err, bit fail, string tag);
    item_t it;
    int i;
    it.due = due; it.v = mk(s, act, err, fail); it.tag = tag;
    i = 0;
    while (i < q.size() && q[i].due <= due) i++;
    q.insert(i, it);
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  // monitor: pops each expected item in the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      if (q[0].due == cyc) begin
        compare(q[0].v, q[0].tag);
      end else begin
        n_chk++; n_bad++;
        $display("FAIL %s: missed due cycle %0d", q[0].tag, q[0].due);
      end
      void'(q.pop_front());
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t;
    cyc = 0; n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; bad_a = 1'b0; bad_b = 1'b0; lock = 1'b0; req = 1'b0; rst_len = '0;
    repeat (3) @(negedge clk);
    compare(mk(S_IDLE, 0, 0, 0), "R1 reset state");

    // bring-up: minimum reset of 2 cycles, then wait for lock
    rst_n = 1'b1; t = cyc;
    expect_at(t + 1, S_RST, 0, 0, 0, "R1 leave IDLE to RESET");
    expect_at(t + 2, S_RST, 0, 0, 0, "R8 reset held min length");
    expect_at(t + 3, S_WAIT, 0, 0, 0, "R9 pd enabled before lock");
    wait_cyc(t + 3);
    lock = 1'b1; t = cyc;
    expect_at(t + 2, S_WAIT, 0, 0, 0, "R3 lock not yet through synchronizer");
    expect_at(t + 3, S_STB, 0, 0, 0, "R3 lock seen after two flops");
    expect_at(t + 6, S_STB, 0, 0, 0, "R11 outputs still gated while qualifying");
    expect_at(t + 7, S_RUN, 0, 0, 0, "R10 RUN after stable lock window");
    wait_cyc(t + 8);

    // user switchover with both references good, reset length 5
    rst_len = 4'd5; req = 1'b1; t = cyc;
    expect_at(t + 1, S_FRZ, 0, 0, 0, "R5 accept request into FREEZE");
    expect_at(t + 2, S_SW, 0, 0, 0, "R5 switch strobe");
    expect_at(t + 3, S_RST, 1, 0, 0, "R5 active toggles into RESET");
    expect_at(t + 7, S_RST, 1, 0, 0, "R8 reset held rst_len cycles");
    expect_at(t + 8, S_WAIT, 1, 0, 0, "R8 reset ends after rst_len");
    wait_cyc(t + 1);
    req = 1'b0; lock = 1'b0;
    wait_cyc(t + 8);
    lock = 1'b1;
    expect_at(t + 11, S_STB, 1, 0, 0, "R10 lock enters STABLE");
    wait_cyc(t + 12);
    lock = 1'b0;
    wait_cyc(t + 13);
    lock = 1'b1;
    expect_at(t + 14, S_STB, 1, 0, 0, "R10 still qualifying");
    expect_at(t + 15, S_WAIT, 1, 0, 0, "R10 lock drop restarts");
    expect_at(t + 16, S_STB, 1, 0, 0, "R10 re-enter STABLE");
    expect_at(t + 19, S_STB, 1, 0, 0, "R10 count restarted from zero");
    expect_at(t + 20, S_RUN, 1, 0, 0, "R11 outputs open after requalify");
    wait_cyc(t + 21);

    // secondary reference fails; a request during the loss is rejected
    bad_b = 1'b1; t = cyc;
    expect_at(t + 2, S_RUN, 1, 0, 0, "R3 bad flag in synchronizer");
    expect_at(t + 3, S_FRZ, 1, 0, 0, "R4 freeze on clock loss");
    wait_cyc(t + 4);
    req = 1'b1;
    expect_at(t + 5, S_FRZ, 1, 1, 0, "R6 request rejected, error set");
    wait_cyc(t + 5);
    req = 1'b0;
    wait_cyc(t + 6);
    bad_b = 1'b0; lock = 1'b0; rst_len = 4'd1;
    expect_at(t + 8, S_FRZ, 1, 1, 0, "R7 held until flag clears");
    expect_at(t + 9, S_RST, 1, 1, 0, "R7 recover without switching");
    expect_at(t + 10, S_RST, 1, 1, 0, "R8 short request clamped to minimum");
    expect_at(t + 11, S_WAIT, 1, 1, 0, "R8 minimum reset length");
    wait_cyc(t + 20);
    req = 1'b1;
    expect_at(t + 21, S_WAIT, 1, 1, 0, "R6 request outside RUN ignored");
    wait_cyc(t + 21);
    req = 1'b0;
    expect_at(t + 22, S_WAIT, 1, 1, 0, "R6 no switch after ignored request");
    expect_at(t + 40, S_WAIT, 1, 1, 0, "R12 still waiting before timeout");
    expect_at(t + 41, S_RST, 1, 1, 1, "R12 timeout retries reset");
    expect_at(t + 42, S_RST, 1, 1, 1, "R12 retry reset length");
    expect_at(t + 43, S_WAIT, 1, 1, 1, "R12 wait lock after retry");
    wait_cyc(t + 43);
    lock = 1'b1;
    expect_at(t + 46, S_STB, 1, 1, 1, "R2 sticky flags held in STABLE");
    expect_at(t + 50, S_RUN, 1, 1, 1, "R2 sticky flags held in RUN");
    wait_cyc(t + 52);

    // primary reference flag also freezes
    bad_a = 1'b1; t = cyc;
    expect_at(t + 3, S_FRZ, 1, 1, 1, "R4 freeze on primary loss");
    wait_cyc(t + 4);
    bad_a = 1'b0;
    expect_at(t + 7, S_RST, 1, 1, 1, "R7 primary recovery to RESET");
    expect_at(t + 9, S_WAIT, 1, 1, 1, "R9 pd back after reset");
    expect_at(t + 10, S_STB, 1, 1, 1, "R10 lock already present");
    expect_at(t + 14, S_RUN, 1, 1, 1, "R11 outputs reopen");
    wait_cyc(t + 16);

    while (q.size() > 0) @(negedge clk);
    finish_run();
  end

endmodule